// File: doc/BRIEF.md
# Die-Temperature Monitor Control and Status Register

This block is one 8-bit register on a simple synchronous register bus. It supervises an on-chip die-temperature monitor. A digital temperature code is compared against two programmable threshold codes. The result is held as an over-temperature status with hysteresis, and that status is forced low whenever the device is not in full-power mode.

Any change of the status, rising or falling, latches a sticky event flag. Software clears the flag by writing 1 to it. When the interrupt enable is set, the flag drives an interrupt request.

The same register holds the routing controls for an analog multiplexer. These controls decide whether the internal converter channel sees the temperature-proportional voltage, the bandgap reference, or the external analog pin. Two upper bits are test bits that can be changed only while a special-mode input is high.

Top module: `tsense_csr`

## Requirements
- R1: After synchronous reset the register reads 0x10, which means only the access-enable bit (bit 4) is set. `over_temp` and `irq` are 0 and `amux_src` is 2'b01.
- R2: The register answers only at address `REG_ADDR` (default 0x2F0). Reads from any other address return 0x00, and writes to any other address change nothing. Read data is combinational on the address. The bit layout is [7:6] test bits, [5] reference select, [4] access enable, [3] sense enable, [2] status, [1] interrupt enable, [0] event flag.
- R3: Bits 7:6 take written data only while `test_mode` is 1. Otherwise they keep their value.
- R4: `amux_src` is 2'b00 (external pin) when bit 4 is 0. With bit 4 set it is 2'b01 (temperature voltage) when bit 5 is 0, and 2'b10 (bandgap) when bit 5 is 1.
- R5: While bit 3 is 0 the status is 0 on the next clock, whatever the temperature.
- R6: With sensing enabled and `full_power` high, the status becomes 1 one clock after `temp_code > thr_hi` and 0 one clock after `temp_code < thr_lo`. Between the two thresholds it holds its value.
- R7: When `full_power` is 0 the status is 0 on the next clock.
- R8: Writes to bit 2 have no effect on the status.
- R9: The event flag sets in the same clock in which the status changes in either direction.
- R10: Writing 1 to bit 0 clears the flag. Writing 0 leaves it unchanged.
- R11: `irq` is 1 exactly when the flag and bit 1 are both 1.
- R12: If a status change and a clearing write occur in the same clock, the flag ends up set.
- R13: Leaving full-power mode does not clear a pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| temp_code | input | TEMP_W | Die-temperature code |
| thr_hi | input | TEMP_W | Assert threshold code |
| thr_lo | input | TEMP_W | Deassert threshold code (below thr_hi) |
| full_power | input | 1 | 1 = full-power mode, 0 = reduced power or shutdown |
| test_mode | input | 1 | Special mode, unlocks bits 7:6 |
| over_temp | output | 1 | Over-temperature status |
| irq | output | 1 | Interrupt request |
| amux_src | output | 2 | Converter channel source: 00 external, 01 temperature, 10 bandgap |

## Verification
The hardest case to reach is a clearing write that lands in the very clock in which the status flips. The bench produces it by releasing reduced-power mode while the temperature sits above the assert threshold, in the same cycle that it issues the write-1 to bit 0, so that both events meet at one edge. A falling status edge, which must also set the flag, is reached by walking the temperature down through the hysteresis band after the flag has been cleared.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    localparam int CSR_W = 8;
    localparam int RSV_W = 2;

    typedef struct packed {
        logic [RSV_W-1:0] rsv;
        logic             vsel;
        logic             vae;
        logic             en;
        logic             stat;
        logic             ie;
        logic             flag;
    } csr_t;

    localparam csr_t CSR_RESET = '{rsv: '0, vsel: 1'b0, vae: 1'b1, en: 1'b0,
                                   stat: 1'b0, ie: 1'b0, flag: 1'b0};

    typedef enum logic [1:0] {
        AMUX_EXT  = 2'b00,
        AMUX_TEMP = 2'b01,
        AMUX_BG   = 2'b10
    } amux_e;

    function automatic amux_e amux_route(input logic vae, input logic vsel);
        if (!vae)      return AMUX_EXT;
        else if (vsel) return AMUX_BG;
        else           return AMUX_TEMP;
    endfunction

endpackage

// File: rtl/tsense_status.sv
module tsense_status #(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              full_power,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] thr_hi,
    input  logic [TEMP_W-1:0] thr_lo,
    output logic              status_o,
    output logic              change_o
);
    logic status_q, status_d;

    always_comb begin
        status_d = status_q;
        if (!en || !full_power)  status_d = 1'b0;
        else if (temp > thr_hi)  status_d = 1'b1;
        else if (temp < thr_lo)  status_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= 1'b0;
        else     status_q <= status_d;
    end

    assign status_o = status_q;
    assign change_o = status_d ^ status_q;

    p_disabled_low_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> !status_q);
    p_rpm_low_r7: assert property (@(posedge clk) disable iff (rst)
        !full_power |=> !status_q);
    p_hyst_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (en && full_power && temp <= thr_hi && temp >= thr_lo) |=> $stable(status_q));
endmodule

// File: rtl/tsense_flag.sv
module tsense_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/tsense_amux.sv
module tsense_amux (
    input  logic                 vae,
    input  logic                 vsel,
    output tsense_pkg::amux_e    src
);
    assign src = tsense_pkg::amux_route(vae, vsel);
endmodule

// File: rtl/tsense_csr.sv
module tsense_csr
    import tsense_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h2F0,
    parameter int              TEMP_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CSR_W-1:0]  bus_wdata,
    output logic [CSR_W-1:0]  bus_rdata,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [TEMP_W-1:0] thr_hi,
    input  logic [TEMP_W-1:0] thr_lo,
    input  logic              full_power,
    input  logic              test_mode,
    output logic              over_temp,
    output logic              irq,
    output logic [1:0]        amux_src
);
    csr_t             wr_csr;
    csr_t             csr_view;
    logic             hit, wr_hit;
    logic [RSV_W-1:0] rsv_q;
    logic             vsel_q, vae_q, en_q, ie_q;
    logic             stat_w, change_w, flag_w;
    amux_e            src_w;
    logic             unused_bits;

    assign wr_csr      = csr_t'(bus_wdata);
    assign hit         = (bus_addr == REG_ADDR);
    assign wr_hit      = hit && bus_wr;
    assign unused_bits = wr_csr.stat;

    // Per-bit lock on the test bits
    for (genvar i = 0; i < RSV_W; i++) begin : g_rsv
        always_ff @(posedge clk) begin
            if (rst)                        rsv_q[i] <= CSR_RESET.rsv[i];
            else if (wr_hit && test_mode)   rsv_q[i] <= wr_csr.rsv[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vsel_q <= CSR_RESET.vsel;
            vae_q  <= CSR_RESET.vae;
            en_q   <= CSR_RESET.en;
            ie_q   <= CSR_RESET.ie;
        end else if (wr_hit) begin
            vsel_q <= wr_csr.vsel;
            vae_q  <= wr_csr.vae;
            en_q   <= wr_csr.en;
            ie_q   <= wr_csr.ie;
        end
    end

    tsense_status #(.TEMP_W(TEMP_W)) i_status (
        .clk        (clk),
        .rst        (rst),
        .en         (en_q),
        .full_power (full_power),
        .temp       (temp_code),
        .thr_hi     (thr_hi),
        .thr_lo     (thr_lo),
        .status_o   (stat_w),
        .change_o   (change_w)
    );

    tsense_flag i_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (change_w),
        .clr_i  (wr_hit && wr_csr.flag),
        .flag_o (flag_w)
    );

    tsense_amux i_amux (
        .vae  (vae_q),
        .vsel (vsel_q),
        .src  (src_w)
    );

    always_comb begin
        csr_view      = '0;
        csr_view.rsv  = rsv_q;
        csr_view.vsel = vsel_q;
        csr_view.vae  = vae_q;
        csr_view.en   = en_q;
        csr_view.stat = stat_w;
        csr_view.ie   = ie_q;
        csr_view.flag = flag_w;
    end

    assign bus_rdata = hit ? csr_view : '0;
    assign over_temp = stat_w;
    assign irq       = flag_w && ie_q;
    assign amux_src  = src_w;

    p_rsv_locked_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !test_mode) |=> $stable(rsv_q));
    p_flag_on_change_r9: assert property (@(posedge clk) disable iff (rst)
        (over_temp != $past(over_temp)) |-> flag_w);
    p_irq_gated_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_w && bus_rdata_ie_ok));

    logic bus_rdata_ie_ok;
    assign bus_rdata_ie_ok = ie_q;
endmodule

// File: tb/test_tsense_csr.sv
`timescale 1ns/100ps
module test_tsense_csr;
    localparam logic [11:0] RA = 12'h2F0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = RA;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  temp_code = 8'd50;
    logic [7:0]  thr_hi = 8'd100;
    logic [7:0]  thr_lo = 8'd80;
    logic        full_power = 1'b1;
    logic        test_mode = 1'b0;
    logic        over_temp, irq;
    logic [1:0]  amux_src;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // scoreboard: kind 0 rdata, 1 irq, 2 over_temp, 3 amux_src
    typedef struct packed { logic [1:0] kind; logic [7:0] exp; } item_t;
    item_t exp_q[$];
    string req_q[$];

    always #2 clk = ~clk;

    tsense_csr i_tsense_csr (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .temp_code(temp_code),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .full_power(full_power),
        .test_mode(test_mode), .over_temp(over_temp), .irq(irq),
        .amux_src(amux_src)
    );

    // monitor
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t it;
            string rq;
            logic [7:0] act;
            it = exp_q.pop_front();
            rq = req_q.pop_front();
            case (it.kind)
                2'd0:    act = bus_rdata;
                2'd1:    act = {7'd0, irq};
                2'd2:    act = {7'd0, over_temp};
                default: act = {6'd0, amux_src};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=0x%02h expected=0x%02h",
                         rq, it.kind, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_addr = RA;
    endtask

    task automatic expect_out(input logic [1:0] k, input logic [7:0] e, input string rq);
        exp_q.push_back('{kind: k, exp: e});
        req_q.push_back(rq);
        @(negedge clk); #1;
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [7:0] e, input string rq);
        bus_addr = a;
        expect_out(2'd0, e, rq);
        bus_addr = RA;
    endtask

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        expect_rd(RA, 8'h10, "R1 reset value");
        expect_out(2'd1, 8'h00, "R1 irq idle");
        expect_out(2'd2, 8'h00, "R1 over_temp idle");
        expect_out(2'd3, 8'h01, "R1 amux reset");
        // R2 decode
        expect_rd(12'h2F1, 8'h00, "R2 other address reads zero");
        wr(12'h2F4, 8'hFF);
        expect_rd(RA, 8'h10, "R2 foreign write ignored");
        // R3 test bits
        wr(RA, 8'hD0);
        expect_rd(RA, 8'h10, "R3 locked in normal mode");
        test_mode = 1'b1;
        wr(RA, 8'hD0);
        expect_rd(RA, 8'hD0, "R3 written in test mode");
        wr(RA, 8'h10);
        test_mode = 1'b0;
        expect_rd(RA, 8'h10, "R3 restored");
        // R4 routing
        wr(RA, 8'h00); expect_out(2'd3, 8'h00, "R4 external");
        wr(RA, 8'h30); expect_out(2'd3, 8'h02, "R4 bandgap");
        wr(RA, 8'h20); expect_out(2'd3, 8'h00, "R4 bandgap without access");
        wr(RA, 8'h10); expect_out(2'd3, 8'h01, "R4 temperature");
        // R5 disabled sensing
        temp_code = 8'd120;
        tick(); tick();
        expect_out(2'd2, 8'h00, "R5 disabled status low");
        expect_rd(RA, 8'h10, "R5 disabled no flag");
        // R6 / R9 rise
        wr(RA, 8'h18);
        tick();
        expect_out(2'd2, 8'h01, "R6 rises above thr_hi");
        expect_rd(RA, 8'h1D, "R9 flag on rising edge");
        expect_out(2'd1, 8'h00, "R11 irq masked");
        // R10 write 0 keeps flag, R11 irq
        wr(RA, 8'h1A);
        expect_rd(RA, 8'h1F, "R10 write zero keeps flag");
        expect_out(2'd1, 8'h01, "R11 irq asserted");
        wr(RA, 8'h1B);
        expect_rd(RA, 8'h1E, "R10 write one clears flag");
        expect_out(2'd1, 8'h00, "R11 irq after clear");
        // R6 hysteresis, R9 falling
        temp_code = 8'd90; tick(); tick();
        expect_out(2'd2, 8'h01, "R6 hold inside band");
        expect_rd(RA, 8'h1E, "R6 no flag inside band");
        temp_code = 8'd70; tick();
        expect_out(2'd2, 8'h00, "R6 falls below thr_lo");
        expect_rd(RA, 8'h1B, "R9 flag on falling edge");
        // R8 status bit not writable
        wr(RA, 8'h1F);
        expect_rd(RA, 8'h1A, "R8 status write ignored");
        temp_code = 8'd90; tick(); tick();
        expect_out(2'd2, 8'h00, "R6 hold low inside band");
        // R7 / R13
        temp_code = 8'd120; tick();
        expect_rd(RA, 8'h1F, "R6 rises again");
        full_power = 1'b0; tick();
        expect_out(2'd2, 8'h00, "R7 reduced power forces low");
        tick(); tick();
        expect_rd(RA, 8'h1B, "R13 flag kept in reduced power");
        expect_out(2'd1, 8'h01, "R13 irq kept in reduced power");
        // R12 set beats clear
        full_power = 1'b1;
        wr(RA, 8'h1B);
        expect_rd(RA, 8'h1F, "R12 set wins over clear");
        wr(RA, 8'h1B);
        expect_rd(RA, 8'h1E, "R12 later clear works");
        tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule